// File: doc/BRIEF.md
# Buffered Page-Write Sequencer

This block writes a byte range of any length and alignment into a page-organised SPI serial flash that has an on-chip SRAM page buffer. It cuts the range into pieces that never cross a page boundary. A piece that covers a whole page is sent straight to the buffered erase-and-program command. A piece that covers only part of a page is handled as read-modify-write: the existing flash page is first copied into the device buffer, and then only the new bytes are programmed over it. After every command that makes the device busy, the block polls the device status until the device reports ready. As an option, it compares the programmed page with the buffer and stops at the first mismatch.

The write data arrives on a byte stream with valid/ready handshaking and is moved straight into the SPI program frame. A request is given as a starting page, a byte offset inside that page, a length and a verify selection, all captured on a one-cycle `start` pulse. At the end, `done` pulses for one cycle. At that point `wr_count` gives the number of bytes that were programmed and checked successfully, and two flags report a rejected range or a compare mismatch.

Top module: `pgw_seq`

## Requirements
- R1: The first piece has length min(length, PAGE_BYTES - start_off). Every later piece starts at offset 0 of the next page and has length min(remaining, PAGE_BYTES).
- R2: A piece shorter than PAGE_BYTES is preceded by a load frame. This frame is opcode 0x53 followed by three address bytes, most significant first. The address is (page << PAGE_SHIFT) and its low byte is 0. A full-page piece gets no load frame.
- R3: Each piece is programmed in one chip-select frame: opcode 0x82, then the three address bytes of (page << PAGE_SHIFT) + offset with the most significant byte first, then the piece's data bytes in stream order. The SPI clock toggles only while chip select is low. Data is accepted only when `in_valid` and `in_ready` are both high.
- R4: After every load, program or compare frame, the block sends status frames until the status byte has bit 7 set. Each status frame is opcode 0xD7 followed by one read byte. No other command is sent while the device reports busy.
- R5: `verify_en` is sampled at `start`. When it is set, each program step is followed by a compare frame: opcode 0x60 with the address (page << PAGE_SHIFT), whose low byte is 0. When it is clear, no compare frame is sent.
- R6: If the status that ends a compare has bit 6 set, the block stops at once and no further frames are sent. `done` pulses with `cmp_err` = 1, and `wr_count` holds only the pieces that finished before the failing one.
- R7: A request is rejected if start_off ≥ PAGE_BYTES or if start_page·PAGE_BYTES + start_off + length > NUM_PAGES·PAGE_BYTES. A rejected request sends no frame. On the cycle after `start`, it shows `done` = 1, `range_err` = 1 and `wr_count` = 0.
- R8: A zero length takes priority over the range check. It sends no frame and shows `done` = 1 on the cycle after `start`, with `wr_count` = 0 and both error flags at 0.
- R9: `wr_count` grows by a piece's length only after that piece has fully completed, including its compare when verify is on. After a successful request it equals the requested length.
- R10: During and after reset, `spi_cs_n` = 1, `spi_sclk` = 0, `in_ready` = 0, `done` = 0, `wr_count` = 0 and both error flags = 0.
- R11: `done` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a request (sampled while idle) |
| start_page | input | PAGE_W | First page of the range |
| start_off | input | PAGE_SHIFT | Byte offset inside the first page |
| length | input | LEN_W | Number of bytes to write |
| verify_en | input | 1 | Compare each page after programming |
| in_data | input | 8 | Write data byte |
| in_valid | input | 1 | Write data byte available |
| in_ready | output | 1 | Block takes the byte this cycle |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | One-cycle end-of-request pulse |
| wr_count | output | LEN_W | Bytes written and completed |
| range_err | output | 1 | Request was rejected for range |
| cmp_err | output | 1 | Compare reported a mismatch |

## Verification
A rejected or zero-length request must raise `done` on the clock edge that follows the edge capturing `start`. The bench therefore samples `done` on the first falling edge after releasing `start`, and insists that no wait cycle occur. An accepted request takes a variable time that depends on how fast the data stream arrives and on how many busy polls the device answers. For such a request the bench waits on `done`, then checks the counts and flags, and then checks on the following falling edge that `done` has dropped again. A behavioural flash model in the bench decodes every SPI frame on the clock edges of the serial bus. It answers status polls with two busy replies and then a ready reply, and it logs opcodes, addresses, data bytes and any command sent while busy. The bench compares this log, after completion, with a piece list it computes itself from the request.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {F_LOAD, F_PROG, F_CMP, F_STAT} frame_t;
  typedef enum logic [1:0] {S_IDLE, S_GAP, S_FRAME, S_CHUNK} state_t;

  localparam logic [7:0] OP_LOAD = 8'h53;
  localparam logic [7:0] OP_PROG = 8'h82;
  localparam logic [7:0] OP_CMP  = 8'h60;
  localparam logic [7:0] OP_STAT = 8'hD7;
endpackage

// File: rtl/pgw_spi_byte.sv
// One SPI mode-0 byte exchange; two clock cycles per bit.
// flags captures the first two bits received (status ready/mismatch).
module pgw_spi_byte (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [1:0] flags
);
  logic [7:0] sh_q, sh_n;
  logic [2:0] bits_q, bits_n;
  logic [1:0] flg_q, flg_n;
  logic       sclk_q, sclk_n, busy_q, busy_n, done_q, done_n;

  always_comb begin
    sh_n = sh_q; bits_n = bits_q; flg_n = flg_q;
    sclk_n = sclk_q; busy_n = busy_q; done_n = 1'b0;
    if (go) begin
      sh_n = tx; bits_n = '0; sclk_n = 1'b0; busy_n = 1'b1;
    end else if (busy_q) begin
      if (!sclk_q) begin
        sclk_n = 1'b1;
      end else begin
        if (bits_q == 3'd0) flg_n[1] = miso;
        if (bits_q == 3'd1) flg_n[0] = miso;
        sh_n = {sh_q[6:0], 1'b0};
        sclk_n = 1'b0;
        bits_n = bits_q + 3'd1;
        if (bits_q == 3'd7) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; bits_q <= '0; flg_q <= '0;
      sclk_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      sh_q <= sh_n; bits_q <= bits_n; flg_q <= flg_n;
      sclk_q <= sclk_n; busy_q <= busy_n; done_q <= done_n;
    end
  end

  assign sclk  = sclk_q;
  assign mosi  = sh_q[7];
  assign busy  = busy_q;
  assign done  = done_q;
  assign flags = flg_q;

  // R3: data line holds still while the clock is high
  a_r3_mosi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sh_q[7]));
endmodule

// File: rtl/pgw_chunk.sv
// Piece length: the smaller of the remaining bytes and the room left in the page.
module pgw_chunk #(
  parameter int PAGE_BYTES = 264,
  parameter int LEN_W      = 20,
  parameter int OFF_W      = 9,
  parameter int CHUNK_W    = 9
) (
  input  logic [LEN_W-1:0]   rem,
  input  logic [OFF_W-1:0]   off,
  output logic [CHUNK_W-1:0] chunk,
  output logic               full
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room  = LEN_W'(PAGE_BYTES) - LEN_W'(off);
    chunk = (rem < room) ? CHUNK_W'(rem) : CHUNK_W'(room);
    full  = (chunk == CHUNK_W'(PAGE_BYTES));
  end
endmodule

// File: rtl/pgw_frame_byte.sv
// Selects the byte to send at position idx of the current frame.
module pgw_frame_byte
  import pgw_pkg::*;
#(
  parameter int PAGE_W = 11,
  parameter int OFF_W  = 9,
  parameter int IDX_W  = 9
) (
  input  frame_t            ftype,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        data,
  output logic [7:0]        tx
);
  logic [23:0]      addr;
  logic [OFF_W-1:0] off_sel;

  always_comb begin
    off_sel = (ftype == F_PROG) ? off : '0;
    addr    = 24'({page, off_sel});
    case (idx)
      IDX_W'(0): begin
        case (ftype)
          F_LOAD:  tx = OP_LOAD;
          F_PROG:  tx = OP_PROG;
          F_CMP:   tx = OP_CMP;
          default: tx = OP_STAT;
        endcase
      end
      IDX_W'(1): tx = (ftype == F_STAT) ? 8'h00 : addr[23:16];
      IDX_W'(2): tx = addr[15:8];
      IDX_W'(3): tx = addr[7:0];
      default:   tx = (ftype == F_PROG) ? data : 8'h00;
    endcase
  end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int NUM_PAGES  = 2048,
  parameter int LEN_W      = 20,
  localparam int PAGE_W    = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [PAGE_SHIFT-1:0] start_off,
  input  logic [LEN_W-1:0]  length,
  input  logic              verify_en,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              done,
  output logic [LEN_W-1:0]  wr_count,
  output logic              range_err,
  output logic              cmp_err
);
  localparam int CHUNK_W   = $clog2(PAGE_BYTES + 1);
  localparam int IDX_W     = $clog2(PAGE_BYTES + 5);
  localparam int DEV_BYTES = NUM_PAGES * PAGE_BYTES;

  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  state_t              st_q, st_n;
  frame_t              ft_q, ft_n, pend_q, pend_n;
  logic [IDX_W-1:0]    idx_q, idx_n, flen;
  logic [PAGE_W-1:0]   page_q, page_n;
  logic [PAGE_SHIFT-1:0] off_q, off_n, ck_off;
  logic [LEN_W-1:0]    rem_q, rem_n, len_q, len_n, cnt_q, cnt_n, ck_rem, rem_left;
  logic [CHUNK_W-1:0]  chunk_q, chunk_n, ck_chunk;
  logic [1:0]          stat_q, stat_n, sp_flags;
  logic                ck_full, ver_q, ver_n, cs_q, cs_n, done_q, done_n;
  logic                rerr_q, rerr_n, cerr_q, cerr_n;
  logic                sp_busy, sp_done, go, can_issue, need_data, frame_end, bad_range;
  logic [7:0]          tx_byte;
  logic [31:0]         reach;

  assign rem_left = rem_q - LEN_W'(chunk_q);
  assign ck_rem   = (st_q == S_IDLE) ? length : rem_left;
  assign ck_off   = (st_q == S_IDLE) ? start_off : '0;

  pgw_chunk #(.PAGE_BYTES(PAGE_BYTES), .LEN_W(LEN_W), .OFF_W(PAGE_SHIFT), .CHUNK_W(CHUNK_W))
    u_chunk (.rem(ck_rem), .off(ck_off), .chunk(ck_chunk), .full(ck_full));

  pgw_frame_byte #(.PAGE_W(PAGE_W), .OFF_W(PAGE_SHIFT), .IDX_W(IDX_W))
    u_fbyte (.ftype(ft_q), .idx(idx_q), .page(page_q), .off(off_q), .data(in_data), .tx(tx_byte));

  pgw_spi_byte u_spi (.clk(clk), .rst_n(rst_i_n), .go(go), .tx(tx_byte), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .busy(sp_busy), .done(sp_done), .flags(sp_flags));

  always_comb begin
    case (ft_q)
      F_PROG:  flen = IDX_W'(4) + IDX_W'(chunk_q);
      F_STAT:  flen = IDX_W'(2);
      default: flen = IDX_W'(4);
    endcase
    need_data = (ft_q == F_PROG) && (idx_q >= IDX_W'(4));
    can_issue = (st_q == S_FRAME) && (idx_q < flen) && !sp_busy && !sp_done;
    go        = can_issue && (!need_data || in_valid);
    frame_end = (st_q == S_FRAME) && (idx_q == flen) && !sp_busy && !sp_done;
    reach     = 32'(start_page) * 32'(PAGE_BYTES) + 32'(start_off) + 32'(length);
    bad_range = (32'(start_off) >= 32'(PAGE_BYTES)) || (reach > 32'(DEV_BYTES));
  end
  assign in_ready = can_issue && need_data;

  always_comb begin
    st_n = st_q; ft_n = ft_q; pend_n = pend_q; idx_n = idx_q;
    page_n = page_q; off_n = off_q; rem_n = rem_q; len_n = len_q;
    cnt_n = cnt_q; chunk_n = chunk_q; stat_n = stat_q; ver_n = ver_q;
    cs_n = cs_q; done_n = 1'b0; rerr_n = rerr_q; cerr_n = cerr_q;
    case (st_q)
      S_IDLE: if (start) begin
        cnt_n = '0; rerr_n = 1'b0; cerr_n = 1'b0;
        ver_n = verify_en; len_n = length; rem_n = length;
        page_n = start_page; off_n = start_off; chunk_n = ck_chunk;
        if (length == '0) begin
          done_n = 1'b1;
        end else if (bad_range) begin
          rerr_n = 1'b1; done_n = 1'b1;
        end else begin
          ft_n = ck_full ? F_PROG : F_LOAD;
          st_n = S_GAP;
        end
      end
      S_GAP: begin
        cs_n = 1'b0; idx_n = '0; st_n = S_FRAME;
      end
      S_FRAME: begin
        if (sp_done) begin
          idx_n = idx_q + IDX_W'(1);
          if (ft_q == F_STAT) stat_n = sp_flags;
        end
        if (frame_end) begin
          cs_n = 1'b1;
          st_n = S_GAP;
          if (ft_q != F_STAT) begin
            pend_n = ft_q; ft_n = F_STAT;
          end else if (stat_q[1]) begin
            case (pend_q)
              F_LOAD: ft_n = F_PROG;
              F_PROG: if (ver_q) ft_n = F_CMP; else st_n = S_CHUNK;
              default: begin
                if (stat_q[0]) begin
                  cerr_n = 1'b1; done_n = 1'b1; st_n = S_IDLE;
                end else begin
                  st_n = S_CHUNK;
                end
              end
            endcase
          end
        end
      end
      default: begin
        cnt_n = cnt_q + LEN_W'(chunk_q);
        rem_n = rem_left;
        if (rem_left == '0) begin
          done_n = 1'b1; st_n = S_IDLE;
        end else begin
          page_n = page_q + PAGE_W'(1); off_n = '0; chunk_n = ck_chunk;
          ft_n = ck_full ? F_PROG : F_LOAD;
          st_n = S_GAP;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= S_IDLE; ft_q <= F_STAT; pend_q <= F_STAT; idx_q <= '0;
      page_q <= '0; off_q <= '0; rem_q <= '0; len_q <= '0; cnt_q <= '0;
      chunk_q <= '0; stat_q <= '0; ver_q <= 1'b0; cs_q <= 1'b1;
      done_q <= 1'b0; rerr_q <= 1'b0; cerr_q <= 1'b0;
    end else begin
      st_q <= st_n; ft_q <= ft_n; pend_q <= pend_n; idx_q <= idx_n;
      page_q <= page_n; off_q <= off_n; rem_q <= rem_n; len_q <= len_n; cnt_q <= cnt_n;
      chunk_q <= chunk_n; stat_q <= stat_n; ver_q <= ver_n; cs_q <= cs_n;
      done_q <= done_n; rerr_q <= rerr_n; cerr_q <= cerr_n;
    end
  end

  assign spi_cs_n  = cs_q;
  assign done      = done_q;
  assign wr_count  = cnt_q;
  assign range_err = rerr_q;
  assign cmp_err   = cerr_q;

  // R3: bus clock and data handshake only inside a chip-select frame
  a_r3_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_i_n)
    spi_sclk |-> !spi_cs_n);
  a_r3_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_ready |-> !spi_cs_n);
  // R1: a piece in flight is never empty and never longer than a page
  a_r1_chunk_bound: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q != S_IDLE) |-> (chunk_q != '0 && chunk_q <= CHUNK_W'(PAGE_BYTES)));
  // R9: a clean finish reports the whole requested length
  a_r9_count_total: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done && !cmp_err && !range_err) |-> (wr_count == len_q));
  // R7: a rejected request leaves the bus idle
  a_r7_reject_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    range_err |-> spi_cs_n);
  // R6: after a mismatch no further frame is opened
  a_r6_stop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmp_err |-> spi_cs_n);
  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done);
endmodule

// File: tb/pgw_seq_tb.sv
module pgw_seq_tb;
  localparam int PB = 12;
  localparam int SH = 4;
  localparam int NP = 16;
  localparam int LW = 16;
  localparam int NV = 9;

  // vectors: page, offset, length, verify, failing page (31 = none), stall
  localparam int V_PAGE [NV] = '{2, 1, 3, 0, 15, 15, 4, 0, 5};
  localparam int V_OFF  [NV] = '{3, 0, 10, 0, 0, 1, 2, 12, 11};
  localparam int V_LEN  [NV] = '{5, 12, 20, 30, 12, 12, 0, 1, 1};
  localparam int V_VER  [NV] = '{0, 0, 1, 1, 0, 0, 0, 0, 1};
  localparam int V_BAD  [NV] = '{31, 31, 31, 1, 31, 31, 31, 31, 31};
  localparam int V_STL  [NV] = '{0, 1, 1, 0, 0, 0, 0, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] start_page = '0;
  logic [SH-1:0] start_off = '0;
  logic [LW-1:0] length = '0;
  logic verify_en = 1'b0;
  logic [7:0] in_data;
  logic in_valid = 1'b0;
  logic in_ready, spi_cs_n, spi_sclk, spi_mosi, done, range_err, cmp_err;
  logic spi_miso = 1'b0;
  logic [LW-1:0] wr_count;

  int total = 0, bad = 0;
  int src_idx = 0;
  int stall = 0;
  int bad_page = 31;

  always #10 clk = ~clk;

  pgw_seq #(.PAGE_BYTES(PB), .PAGE_SHIFT(SH), .NUM_PAGES(NP), .LEN_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_page(start_page), .start_off(start_off),
    .length(length), .verify_en(verify_en), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .done(done), .wr_count(wr_count), .range_err(range_err),
    .cmp_err(cmp_err));

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 3 + 1) & 255);
  endfunction

  assign in_data = pat(src_idx);

  // stream source: count the handshake seen before the last edge, then drive anew
  initial begin
    bit vv, rr;
    int cyc;
    vv = 1'b0; rr = 1'b0; cyc = 0;
    forever begin
      @(negedge clk);
      if (vv && rr) src_idx++;
      cyc++;
      in_valid = (stall != 0) ? ((cyc % 3) != 0) : 1'b1;
      vv = in_valid;
      rr = in_ready;
    end
  end

  // flash model
  bit in_frame = 1'b0;
  int m_bits = 0, m_nb = 0, busy_left = 0, nlog = 0, dcount = 0, polls = 0, viol = 0, nframes = 0;
  bit mism = 1'b0;
  logic [7:0] m_sh = '0, m_op = '0;
  logic [23:0] m_addr = '0;
  logic [7:0] log_op [64];
  int log_addr [64];
  int log_n [64];
  logic [7:0] dbuf [256];
  logic [7:0] stat;
  assign stat = {busy_left == 0, mism, 6'b0};

  always @(posedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      if (in_frame) begin
        in_frame = 1'b0;
        nframes++;
        if (m_op == 8'hD7) begin
          polls++;
          if (busy_left > 0) busy_left--;
        end else begin
          if (busy_left != 0) viol++;
          log_op[nlog] = m_op;
          log_addr[nlog] = int'(m_addr);
          log_n[nlog] = (m_op == 8'h82 && m_nb > 4) ? m_nb - 4 : 0;
          nlog++;
          busy_left = 2;
          if (m_op == 8'h60) mism = (int'(m_addr >> SH) == bad_page);
        end
      end
    end else begin
      if (!in_frame) begin
        in_frame = 1'b1; m_bits = 0; m_nb = 0; m_addr = '0;
      end
      m_sh = {m_sh[6:0], spi_mosi};
      m_bits++;
      if (m_bits == 8) begin
        m_bits = 0;
        if (m_nb == 0) m_op = m_sh;
        else if (m_nb <= 3) m_addr = {m_addr[15:0], m_sh};
        else if (m_op == 8'h82) begin
          dbuf[dcount] = m_sh;
          dcount++;
        end
        m_nb++;
      end
    end
  end

  always @(negedge spi_sclk)
    if (!spi_cs_n)
      spi_miso <= (m_op == 8'hD7 && m_nb >= 1) ? stat[3'(7 - m_bits)] : 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e_op [64];
    int e_addr [64];
    int e_n [64];
    int nexp, ecnt, eerr, p, o, r, c, t, bl, bfr, bp, bd, bs, bv, pbytes;
    bit rej, zero;

    // reset state (R10)
    repeat (3) @(negedge clk);
    chk("R10 cs_n", int'(spi_cs_n), 1);
    chk("R10 sclk", int'(spi_sclk), 0);
    chk("R10 in_ready", int'(in_ready), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 count", int'(wr_count), 0);
    chk("R10 flags", int'({range_err, cmp_err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle after release", int'({spi_cs_n, spi_sclk, done}), 4);

    for (int v = 0; v < NV; v++) begin
      // expected result from the requirements
      zero = (V_LEN[v] == 0);
      rej = !zero && (V_OFF[v] >= PB || V_PAGE[v] * PB + V_OFF[v] + V_LEN[v] > NP * PB);
      nexp = 0; ecnt = 0; eerr = 0; pbytes = 0;
      p = V_PAGE[v]; o = V_OFF[v]; r = (zero || rej) ? 0 : V_LEN[v];
      while (r > 0) begin
        c = (r < PB - o) ? r : PB - o;
        if (c != PB) begin
          e_op[nexp] = 8'h53; e_addr[nexp] = p << SH; e_n[nexp] = 0; nexp++;
        end
        e_op[nexp] = 8'h82; e_addr[nexp] = (p << SH) + o; e_n[nexp] = c; nexp++;
        pbytes += c;
        if (V_VER[v] != 0) begin
          e_op[nexp] = 8'h60; e_addr[nexp] = p << SH; e_n[nexp] = 0; nexp++;
          if (p == V_BAD[v]) begin
            eerr = 1;
            break;
          end
        end
        ecnt += c; r -= c; p++; o = 0;
      end

      bl = nlog; bfr = nframes; bp = polls; bd = dcount; bs = src_idx; bv = viol;
      @(negedge clk);
      stall = V_STL[v]; bad_page = V_BAD[v];
      start_page = 4'(V_PAGE[v]); start_off = SH'(V_OFF[v]);
      length = LW'(V_LEN[v]); verify_en = (V_VER[v] != 0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 20000) begin
        @(negedge clk);
        t++;
      end
      chk("R11 done seen", int'(done), 1);
      chk("R9 count", int'(wr_count), ecnt);
      chk("R6 cmp_err", int'(cmp_err), eerr);
      chk("R7 range_err", int'(range_err), int'(rej));
      if (zero) begin
        chk("R8 zero-length latency", t, 0);
        chk("R8 zero-length no frame", nframes - bfr, 0);
      end else if (rej) begin
        chk("R7 reject latency", t, 0);
        chk("R7 reject no frame", nframes - bfr, 0);
      end else begin
        chk("R1 command frame count", nlog - bl, nexp);
        for (int i = 0; i < nexp && i < nlog - bl; i++) begin
          // R2 load frames, R3 program frames, R5 compare frames
          if (e_op[i] == 8'h53) begin
            chk("R2 opcode", int'(log_op[bl + i]), e_op[i]);
            chk("R2 address", log_addr[bl + i], e_addr[i]);
          end else if (e_op[i] == 8'h82) begin
            chk("R3 opcode", int'(log_op[bl + i]), e_op[i]);
            chk("R3 address", log_addr[bl + i], e_addr[i]);
          end else begin
            chk("R5 opcode", int'(log_op[bl + i]), e_op[i]);
            chk("R5 address", log_addr[bl + i], e_addr[i]);
          end
          chk("R1 piece length", log_n[bl + i], e_n[i]);
        end
        chk("R4 status polls", polls - bp, 3 * nexp);
        chk("R4 no command while busy", viol - bv, 0);
        chk("R3 data bytes taken", src_idx - bs, pbytes);
        chk("R3 data bytes sent", dcount - bd, pbytes);
        for (int k = bd; k < dcount; k++)
          chk("R3 data order", int'(dbuf[k]), int'(pat(k)));
      end
      @(negedge clk);
      chk("R11 done drops", int'(done), 0);
      repeat (5) @(negedge clk);
    end

    // directed: reset in the middle of a request returns to the reset state (R10)
    @(negedge clk);
    start_page = 4'd6; start_off = '0; length = LW'(24); verify_en = 1'b1; bad_page = 31;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 cs_n after mid reset", int'(spi_cs_n), 1);
    chk("R10 in_ready after mid reset", int'(in_ready), 0);
    chk("R10 count after mid reset", int'(wr_count), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule